// File: doc/BRIEF.md
# Scrambled-Map Interrupt Controller

This block gathers 64 active-low interrupt sources into one interrupt line. Software sees the sources through two 32-bit enable words and two 32-bit pending words. Each source sits at a fixed but non-arithmetic word and bit position. A pending bit is acknowledged by writing a one to it. A read-only vector register reports the number of the winning source in its top six bits.

Most sources are fixed active-low level inputs. Two groups can instead latch falling edges: sources 19 to 25 and sources 48 to 63. Each of these is switched by its own bit in an edge-select register, and that register's bit order is reversed relative to the source numbers. Source 0 is reserved and never becomes pending. All inputs pass through a two-stage synchronizer before detection.

Top module: `sm_intc`

## Requirements
- R1: After reset, both enable words, both pending words, the edge-select register, the vector register and irq_o all read 0.
- R2: Register addresses: 0 enable-high, 1 enable-low, 2 pending-high, 3 pending-low, 4 edge-select, 5 vector. Writes take effect at the clock edge. Reads return the addressed register combinationally, and unused addresses read 0.
- R3: Word placement goes by blocks of 16: sources 0-15 and 32-47 live in the high word, sources 16-31 and 48-63 in the low word. Bit positions are as follows. Source s in 1-15 uses high bit 16-s. Source s in 32-47 uses high bit 63-s. Source 16 uses low bit 2, 17 uses low bit 1, 18 uses low bit 0. Source s in 19-30 uses low bit 33-s, source 31 uses low bit 15, and source s in 48-63 uses low bit s-32.
- R4: An enable bit of 1 lets its source drive irq_o and the vector. A 0 blocks it. The enable bits never change what the pending words read.
- R5: In level mode, a source's pending bit reads 1 from the second clock edge after its input goes low. It reads 0 from the second edge after the input returns high.
- R6: Edge-select bit 33-s controls source s in 19-25. Bit 79-s controls source s in 48-63. Only these 23 bits are writable (mask 0xFFFF7F00); all other bits read 0. A set bit selects falling-edge mode, a clear bit level mode.
- R7: In edge mode, a falling edge on the synchronized input sets the pending bit. The bit then holds after the input returns high, until a one is written to it. Writing 0 to it leaves it set.
- R8: Vector bits [31:26] hold the lowest-numbered source that is both pending and enabled, ignoring source 0. All other bits are 0. A value of 0 means nothing is active. Source 0 never reads pending.
- R9: irq_o is high exactly when some source other than 0 is both pending and enabled.
- R10: When an acknowledge write and a new falling edge hit the same edge-mode bit in the same cycle, the bit stays set.
- R11: Writes to the vector address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 64 | Interrupt sources, active low, index = source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An acknowledge write and a fresh falling edge can land on the same edge-mode pending bit in the same cycle. The bench first latches an edge on source 50 and releases the input. It then drives the input low again, timing the pending-low write so that it clocks in on exactly the edge where the synchronized fall is seen. The bit must read 1 afterwards. A second acknowledge, with the input still low and no new fall, must then clear it.

// File: rtl/sm_ic_pkg.sv
`timescale 1ns/1ps
package sm_ic_pkg;
  localparam int unsigned NSRC = 64;
  localparam int unsigned DW   = 32;
  localparam int unsigned VW   = $clog2(NSRC);

  typedef enum logic [2:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_ESEL    = 3'd4,
    A_VEC     = 3'd5
  } reg_addr_e;

  function automatic bit src_in_lo(int s);
    return ((s / 16) % 2) == 1;
  endfunction

  function automatic int src_bit(int s);
    if (s < 16) return (s == 0) ? 0 : 16 - s;
    if (s < 19) return 18 - s;
    if (s < 31) return 33 - s;
    if (s == 31) return 15;
    if (s < 48) return 63 - s;
    return s - 32;
  endfunction

  function automatic bit src_prog(int s);
    return (s >= 19 && s <= 25) || (s >= 48 && s <= 63);
  endfunction

  function automatic int esel_bit(int s);
    return (s < 48) ? 33 - s : 79 - s;
  endfunction

  function automatic logic [DW-1:0] esel_mask();
    logic [DW-1:0] m = '0;
    for (int s = 0; s < int'(NSRC); s++)
      if (src_prog(s)) m[esel_bit(s)] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] ESEL_MASK = esel_mask();
endpackage

// File: rtl/ic_sync.sv
`timescale 1ns/1ps
module ic_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ic_pend.sv
`timescale 1ns/1ps
module ic_pend #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_ni,
  input  logic [W-1:0] edge_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, eq_q, fall;

  assign fall = prev_q & ~lvl_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      eq_q   <= '0;
    end else begin
      prev_q <= lvl_ni;
      // new edge beats a same-cycle acknowledge
      eq_q   <= edge_en_i & (fall | (eq_q & ~clr_i));
    end
  end

  assign pend_o = (edge_en_i & eq_q) | (~edge_en_i & ~lvl_ni);

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_fall_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_en_i[i] && fall[i] |=> eq_q[i]);
    p_w1c_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_en_i[i] && clr_i[i] && !fall[i] |=> !eq_q[i]);
  end
endmodule

// File: rtl/ic_prio.sv
`timescale 1ns/1ps
module ic_prio #(
  parameter int unsigned N  = 64,
  localparam int unsigned NW = $clog2(N)
) (
  input  logic [N-1:0]  act_i,
  output logic [NW-1:0] num_o,
  output logic          any_o
);
  always_comb begin
    num_o = '0;
    for (int i = int'(N) - 1; i >= 1; i--)
      if (act_i[i]) num_o = NW'(i);
  end

  assign any_o = |act_i[N-1:1];
endmodule

// File: rtl/sm_intc.sv
`timescale 1ns/1ps
module sm_intc
  import sm_ic_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_ni,
  input  logic            wr_en_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  logic [NSRC-1:0] sync_n, edge_en, clr, pend, en;
  logic [DW-1:0]   mask_hi_q, mask_lo_q, esel_q, pend_hi, pend_lo;
  logic [VW-1:0]   vec_num;
  logic            any_act;

  // source 0 is reserved: tie its input inactive
  ic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i({src_ni[NSRC-1:1], 1'b1}), .q_o(sync_n)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_map
    localparam int B = src_bit(s);
    if (src_in_lo(s)) begin : g_lo
      assign en[s]      = mask_lo_q[B];
      assign pend_lo[B] = pend[s];
      assign clr[s]     = wr_en_i && (addr_i == A_PEND_LO) && wdata_i[B];
    end else begin : g_hi
      assign en[s]      = mask_hi_q[B];
      assign pend_hi[B] = pend[s];
      assign clr[s]     = wr_en_i && (addr_i == A_PEND_HI) && wdata_i[B];
    end
    if (src_prog(s)) begin : g_prog
      assign edge_en[s] = esel_q[esel_bit(s)];
    end else begin : g_fixed
      assign edge_en[s] = 1'b0;
    end
  end

  ic_pend #(.W(NSRC)) i_pend (
    .clk_i, .rst_ni, .lvl_ni(sync_n), .edge_en_i(edge_en), .clr_i(clr), .pend_o(pend)
  );

  ic_prio #(.N(NSRC)) i_prio (
    .act_i(pend & en), .num_o(vec_num), .any_o(any_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_hi_q <= '0;
      mask_lo_q <= '0;
      esel_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK_HI: mask_hi_q <= wdata_i;
        A_MASK_LO: mask_lo_q <= wdata_i;
        A_ESEL:    esel_q    <= wdata_i & ESEL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_MASK_HI: rdata_o = mask_hi_q;
      A_MASK_LO: rdata_o = mask_lo_q;
      A_PEND_HI: rdata_o = pend_hi;
      A_PEND_LO: rdata_o = pend_lo;
      A_ESEL:    rdata_o = esel_q;
      A_VEC:     rdata_o = {vec_num, {(DW-VW){1'b0}}};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = any_act;

  p_irq_vec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec_num != '0));
  p_vec_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_num != '0 |-> pend[vec_num] && en[vec_num]);
  p_src0_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_hi[0]);
endmodule

// File: tb/test_sm_intc.sv
`timescale 1ns/1ps
module test_sm_intc;
  localparam logic [2:0] AMH = 3'd0, AML = 3'd1, APH = 3'd2, APL = 3'd3, AES = 3'd4, AVC = 3'd5;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, done = 1'b0;
  logic [63:0] src_n = '1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sm_intc i_sm_intc (
    .clk_i(clk), .rst_ni(rst_n), .src_ni(src_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit b_lo(int s);
    return (s >= 16 && s < 32) || s >= 48;
  endfunction
  function automatic int b_bit(int s);
    if (s == 16) return 2;
    if (s == 17) return 1;
    if (s == 18) return 0;
    if (s == 31) return 15;
    if (s >= 1 && s <= 15) return 16 - s;
    if (s >= 19 && s <= 30) return 33 - s;
    if (s >= 32 && s <= 47) return 63 - s;
    if (s >= 48) return s - 32;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 6; a++) begin rd(a[2:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(AMH, 32'hA5A5_0F0F); wr(AML, 32'h1234_8001);
    rd(AMH, d); chk("R2 mask hi", d, 32'hA5A5_0F0F);
    rd(AML, d); chk("R2 mask lo", d, 32'h1234_8001);
    rd(3'd6, d); chk("R2 unused", d, 0);
    rd(APH, d); chk("R4 pend unaffected", d, 0);
    wr(AMH, 0); wr(AML, 0);
  endtask

  task automatic t_level_map;
    int srcs[12] = '{1, 15, 16, 17, 18, 19, 30, 31, 32, 47, 48, 63};
    logic [31:0] h, l, eh, el;
    foreach (srcs[k]) begin
      int s = srcs[k];
      src_n[s] = 1'b0; cyc(3);
      eh = b_lo(s) ? 0 : 32'd1 << b_bit(s);
      el = b_lo(s) ? 32'd1 << b_bit(s) : 0;
      rd(APH, h); rd(APL, l);
      chk($sformatf("R3 hi src%0d", s), h, eh);
      chk($sformatf("R5 lo src%0d", s), l, el);
      src_n[s] = 1'b1; cyc(3);
      rd(APH, h); rd(APL, l);
      chk($sformatf("R5 release src%0d", s), h | l, 0);
    end
  endtask

  task automatic t_mask_vec;
    logic [31:0] d;
    src_n[5] = 1'b0; src_n[40] = 1'b0; src_n[0] = 1'b0; cyc(3);
    chk("R4 masked irq", {31'b0, irq}, 0);
    rd(AVC, d); chk("R8 none", d, 0);
    rd(APH, d); chk("R4 pend visible", d, (32'd1 << 11) | (32'd1 << 23));
    wr(AMH, 32'd1 << 23);
    rd(AVC, d); chk("R8 vec 40", d, 32'd40 << 26);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(AMH, (32'd1 << 23) | (32'd1 << 11) | 32'd1);
    rd(AVC, d); chk("R8 vec 5", d, 32'd5 << 26);
    wr(AVC, 32'hFFFF_FFFF);
    rd(AVC, d); chk("R11 vec ro", d, 32'd5 << 26);
    src_n[5] = 1'b1; src_n[40] = 1'b1; cyc(3);
    rd(AVC, d); chk("R8 src0 excluded", d, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    src_n[0] = 1'b1; wr(AMH, 0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(AES, 32'hFFFF_FFFF);
    rd(AES, d); chk("R6 esel mask", d, 32'hFFFF_7F00);
    wr(AES, (32'd1 << 13) | (32'd1 << 29));
    wr(AML, 32'd1 << 13);
    src_n[20] = 1'b0; cyc(4); src_n[20] = 1'b1; cyc(4);
    rd(APL, d); chk("R7 edge held", d, 32'd1 << 13);
    rd(AVC, d); chk("R8 vec 20", d, 32'd20 << 26);
    wr(APL, 0);
    rd(APL, d); chk("R7 w0 no effect", d, 32'd1 << 13);
    wr(APL, 32'd1 << 13);
    rd(APL, d); chk("R7 w1c", d, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    src_n[21] = 1'b0; cyc(4); src_n[21] = 1'b1; cyc(4);
    rd(APL, d); chk("R6 src21 level", d, 0);
    wr(AML, 0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    src_n[50] = 1'b0; cyc(4); src_n[50] = 1'b1; cyc(4);
    rd(APL, d); chk("R7 src50 latched", d, 32'd1 << 18);
    src_n[50] = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    addr = APL; wdata = 32'd1 << 18; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    rd(APL, d); chk("R10 set wins", d, 32'd1 << 18);
    wr(APL, 32'd1 << 18);
    rd(APL, d); chk("R10 later clear", d, 0);
    src_n[50] = 1'b1; cyc(3);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    t_reset;
    t_regs;
    t_level_map;
    t_mask_vec;
    t_edge;
    t_collide;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hang exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule